// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block forms the partial products for a parallel decimal multiplier. It takes a multiplicand and a multiplier, each a group of BCD digits. Each multiplier digit is rewritten as a signed decimal digit in the range -5 to +5, and that digit picks a signed multiple of the multiplicand. All multiples are carried in excess-3 digits. Negating an excess-3 digit by bit inversion gives the excess-3 code of its nine's complement, so a negative multiple costs only one XOR level.

A multiplier of DIGITS digits gives DIGITS partial products. It also gives one more, driven by the transfer out of its top digit. Each partial product comes with a sign flag. The reduction stage that follows treats a set flag as a +1 injected at that product's least significant digit, which turns the nine's complement into a ten's complement.

The generator logic is combinational. It sits behind a single output register with a valid/ready handshake. An operand pair is taken on a rising edge when `in_valid` and `in_ready` are both high. The register holds its result, and `out_valid` stays high, until the consumer raises `out_ready`. `in_ready` is high whenever the register is empty or is being drained in the same cycle, so the block takes one pair per cycle with no bubbles.

Top module: `ppg_sd10`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A pair accepted on a rising edge shows up on the outputs, with `out_valid` high, right after that same edge, and results leave in the order they were accepted.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pp` and `out_neg` do not change.
- R4: Multiplier digit k is recoded as v_k = y_k - 10*t_(k+1) + t_k, where t_(k+1) = 1 exactly when y_k >= 5 and t_0 = 0. Every v_k lies in [-5, 5].
- R5: Partial product k, for k < DIGITS, has the value v_k*X. Partial product DIGITS has the value t_DIGITS*X, and its sign flag is always 0.
- R6: Each partial product has DIGITS+1 four-bit fields. Partial product k sits at `out_pp[k*W +: W]` with W = 4*(DIGITS+1), and field i at bits [4i+3:4i] of that slice. A non-negative product stores decimal digit d as d+3, so every field is in 3..12.
- R7: When v_k < 0, `out_neg[k]` is 1 and every field holds the bit inverse of the excess-3 code of |v_k|*X. Read as excess-3, the fields are the nine's complement over DIGITS+1 digits.
- R8: When v_k = 0, every field of partial product k is 4'b0011 and `out_neg[k]` is 0.
- R9: The sum over k of 10^k times the signed value of partial product k equals X*Y. A negative product counts as minus the nine's complement of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_x | input | 4*DIGITS | Multiplicand, BCD, digit i at bits [4i+3:4i] |
| in_y | input | 4*DIGITS | Multiplier, BCD, digit i at bits [4i+3:4i] |
| out_valid | output | 1 | Partial products present |
| out_ready | input | 1 | Consumer takes the partial products this cycle |
| out_pp | output | 4*(DIGITS+1)^2 | DIGITS+1 excess-3 partial products |
| out_neg | output | DIGITS+1 | Per-product sign flag, also the +1 correction |

## Verification
Each result is due on the outputs one rising edge after its operands are accepted. The register is the only stage, so the expected latency is exactly one cycle. The driver pushes the expected product and operands into a queue at the edge where it sees the pair accepted. The monitor samples on falling edges, so every output has settled by then. It pops one entry for each falling edge where both `out_valid` and `out_ready` are high, which keeps the comparisons in arrival order however the consumer stalls. On stalled cycles it compares the held outputs with the values from the previous falling edge.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // BCD digit doubled, with the low neighbour's transfer folded in.
  // The result always stays below 10, so no carry ripples further.
  function automatic logic [3:0] dbl_digit(input logic [3:0] d, input logic lo_xfer);
    logic [4:0] t;
    t = {d, 1'b0};
    if (d >= 4'd5) t = t - 5'd10;
    t = t + {4'd0, lo_xfer};
    return t[3:0];
  endfunction

  function automatic logic [3:0] to_xs3(input logic [3:0] d);
    return d + 4'd3;
  endfunction

endpackage

// File: rtl/ppg_recoder.sv
module ppg_recoder #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0]  y_bcd,
  output logic [DIGITS:0][5:0] sel,
  output logic [DIGITS:0]      neg
);
  always_comb begin
    logic              t_in;
    logic              t_out;
    logic [3:0]        yk;
    logic signed [5:0] v;
    logic [2:0]        mag;
    t_in = 1'b0;
    for (int k = 0; k < DIGITS; k++) begin
      yk    = y_bcd[4*k +: 4];
      t_out = (yk >= 4'd5);
      v     = $signed({2'b00, yk}) + (t_in ? 6'sd1 : 6'sd0) - (t_out ? 6'sd10 : 6'sd0);
      neg[k] = v[5];
      mag    = v[5] ? 3'(-v) : 3'(v);
      sel[k] = 6'b000001 << mag;
      t_in   = t_out;
    end
    sel[DIGITS] = t_in ? 6'b000010 : 6'b000001;
    neg[DIGITS] = 1'b0;
  end
endmodule

// File: rtl/ppg_multiples.sv
module ppg_multiples
  import ppg_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0]             x_bcd,
  output logic [5:0][4*(DIGITS+1)-1:0]    mult
);
  localparam int ND = DIGITS + 1;

  logic [ND-1:0][3:0] m1, m2, m3, m4, m5;

  always_comb begin
    logic [4:0] s;
    logic       c;
    m1 = '0;
    for (int i = 0; i < DIGITS; i++) m1[i] = x_bcd[4*i +: 4];
    // 2X and 4X: digit doubling, one-level transfer from the lower digit
    for (int i = 0; i < ND; i++)
      m2[i] = dbl_digit(m1[i], (i > 0) ? (m1[(i > 0) ? i-1 : 0] >= 4'd5) : 1'b0);
    for (int i = 0; i < ND; i++)
      m4[i] = dbl_digit(m2[i], (i > 0) ? (m2[(i > 0) ? i-1 : 0] >= 4'd5) : 1'b0);
    // 5X: odd digit gives 5, lower neighbour contributes its half
    for (int i = 0; i < ND; i++)
      m5[i] = (m1[i][0] ? 4'd5 : 4'd0) + ((i > 0) ? {1'b0, m1[(i > 0) ? i-1 : 0][3:1]} : 4'd0);
    // 3X = 2X + X, decimal digit sum with transfer chain
    c = 1'b0;
    for (int i = 0; i < ND; i++) begin
      s = {1'b0, m2[i]} + {1'b0, m1[i]} + {4'd0, c};
      if (s >= 5'd10) begin
        m3[i] = 4'(s - 5'd10);
        c     = 1'b1;
      end else begin
        m3[i] = s[3:0];
        c     = 1'b0;
      end
    end
    for (int i = 0; i < ND; i++) begin
      mult[0][4*i +: 4] = to_xs3(4'd0);
      mult[1][4*i +: 4] = to_xs3(m1[i]);
      mult[2][4*i +: 4] = to_xs3(m2[i]);
      mult[3][4*i +: 4] = to_xs3(m3[i]);
      mult[4][4*i +: 4] = to_xs3(m4[i]);
      mult[5][4*i +: 4] = to_xs3(m5[i]);
    end
  end
endmodule

// File: rtl/ppg_select.sv
module ppg_select #(
  parameter int W = 20
) (
  input  logic [5:0][W-1:0] mult,
  input  logic [5:0]        sel,
  input  logic              neg,
  output logic [W-1:0]      pp
);
  always_comb begin
    logic [W-1:0] pick;
    pick = '0;
    for (int m = 0; m < 6; m++)
      if (sel[m]) pick = pick | mult[m];
    pp = pick ^ {W{neg}};
  end
endmodule

// File: rtl/ppg_sd10.sv
module ppg_sd10 #(
  parameter int DIGITS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [4*DIGITS-1:0]                in_x,
  input  logic [4*DIGITS-1:0]                in_y,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [4*(DIGITS+1)*(DIGITS+1)-1:0] out_pp,
  output logic [DIGITS:0]                    out_neg
);
  localparam int NP  = DIGITS + 1;
  localparam int W   = 4 * NP;
  localparam int PPW = W * NP;

  logic [NP-1:0][5:0]  sel_w;
  logic [NP-1:0]       neg_w;
  logic [5:0][W-1:0]   mult_w;
  logic [PPW-1:0]      pp_w;
  logic                take;

  ppg_recoder #(.DIGITS(DIGITS)) u_rec (
    .y_bcd (in_y),
    .sel   (sel_w),
    .neg   (neg_w)
  );

  ppg_multiples #(.DIGITS(DIGITS)) u_mul (
    .x_bcd (in_x),
    .mult  (mult_w)
  );

  for (genvar k = 0; k < NP; k++) begin : g_pp
    ppg_select #(.W(W)) u_sel (
      .mult (mult_w),
      .sel  (sel_w[k]),
      .neg  (neg_w[k]),
      .pp   (pp_w[k*W +: W])
    );

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot(sel_w[k]));
    // R8
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_w[k][0]) |-> !neg_w[k]);
    // R7
    neg_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_neg[k]) |-> out_pp[k*W + W-1]);
    // R6
    pos_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_neg[k]) |-> !out_pp[k*W + W-1]);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pp    <= '0;
      out_neg   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_pp    <= pp_w;
        out_neg   <= neg_w;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R3
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pp) && $stable(out_neg)));
  // R2
  take_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  // R5
  extra_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_neg[DIGITS]);
endmodule

// File: tb/sim_ppg_sd10.sv
module sim_ppg_sd10;
  localparam int D   = 4;
  localparam int NP  = D + 1;
  localparam int W   = 4 * NP;
  localparam int PPW = W * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*D-1:0] in_x = '0;
  logic [4*D-1:0] in_y = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [PPW-1:0] out_pp;
  logic [NP-1:0] out_neg;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  bit done = 0;
  longint exp_q[$];
  int xq[$];
  int yq[$];

  always #5 clk = ~clk;

  ppg_sd10 #(.DIGITS(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_pp(out_pp), .out_neg(out_neg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4*D-1:0] to_bcd(input int v);
    logic [4*D-1:0] r;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic send(input int x, input int y);
    bit acc;
    in_x = to_bcd(x);
    in_y = to_bcd(y);
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      acc = in_ready;
      chk(in_ready == (!out_valid || out_ready), "R2 in_ready", longint'(in_ready), longint'(!out_valid || out_ready));
      @(posedge clk);
      if (acc) break;
      #1;
    end
    exp_q.push_back(longint'(x) * longint'(y));
    xq.push_back(x);
    yq.push_back(y);
    sent++;
    #1;
    in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #2;
      n++;
      out_ready = (n % 7 == 3 || n % 5 == 1) ? 1'b0 : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [PPW-1:0] prev_pp;
    logic [NP-1:0]  prev_neg;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        stalled = 0;
        continue;
      end
      if (stalled) begin
        chk(out_valid && out_pp == prev_pp && out_neg == prev_neg, "R3 held while stalled",
            longint'(out_pp[31:0]), longint'(prev_pp[31:0]));
      end
      stalled = out_valid && !out_ready;
      prev_pp = out_pp;
      prev_neg = out_neg;
      if (out_valid && out_ready) begin
        longint expv, tot;
        int x, y, t, yk, tn;
        expv = exp_q.pop_front();
        x = xq.pop_front();
        y = yq.pop_front();
        tot = 0;
        t = 0;
        for (int k = 0; k < NP; k++) begin
          int v;
          longint mag, val;
          bit fields_ok;
          if (k < D) begin
            yk = (y / (10 ** k)) % 10;
            tn = (yk >= 5) ? 1 : 0;
            v = yk - 10 * tn + t;
            t = tn;
          end else begin
            v = t;
          end
          mag = 0;
          fields_ok = 1;
          for (int i = NP - 1; i >= 0; i--) begin
            logic [3:0] f;
            f = out_pp[k*W + 4*i +: 4];
            if (out_neg[k]) f = ~f;
            if (f < 4'd3 || f > 4'd12) fields_ok = 0;
            mag = mag * 10 + longint'(f) - 3;
          end
          val = out_neg[k] ? -mag : mag;
          chk(v >= -5 && v <= 5, "R4 recoded digit range", longint'(v), 0);
          chk(fields_ok, "R6 field in 3..12", longint'(out_pp[k*W +: 32'(W)]), 0);
          if (k < D)
            chk(val == longint'(v) * x, "R5 pp value", val, longint'(v) * x);
          else
            chk(val == longint'(v) * x && !out_neg[k], "R5 extra pp", val, longint'(v) * x);
          if (v < 0)
            chk(out_neg[k] == 1'b1 && mag == longint'(-v) * x, "R7 negative pp", mag, longint'(-v) * x);
          if (v == 0)
            chk(out_pp[k*W +: W] == {NP{4'b0011}} && !out_neg[k], "R8 zero pp",
                longint'(out_pp[k*W +: W]), longint'({NP{4'b0011}}));
          tot = tot + val * (10 ** k);
        end
        chk(tot == expv, "R9 weighted sum", tot, expv);
        got++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", got, sent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    @(posedge clk);
    #1;
    // one-cycle latency check: send with consumer state known
    send(1234, 5678);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 result one edge after accept", longint'(out_valid), 1);
    // corner operands
    send(0, 0);
    send(9999, 9999);
    send(9999, 0);
    send(0, 9999);
    send(5555, 5555);
    send(4444, 4444);
    send(4949, 9494);
    send(3333, 3334);
    send(6666, 6666);
    send(1, 5);
    for (int d = 0; d < 10; d++) send(7389, d * 1111);
    for (int n = 0; n < 150; n++) send($urandom % 10000, $urandom % 10000);
    // drain
    repeat (20) @(posedge clk);
    chk(got == sent && exp_q.size() == 0, "R2 all results in order", longint'(got), longint'(sent));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule